// File: doc/BRIEF.md
# Automatic Clock Source Selector With Activity Detection

This block chooses the clock that runs a converter's control logic. Two sources are available: an on-chip oscillator, seen here as the input `int_clk_i` together with an enable output `osc_en_o`, and a clock pin `ext_clk_i` that a board may drive. No select input exists. The block watches the pin. When the pin has toggled steadily for a qualification time of a few microseconds, the logic moves to the pin's clock and the oscillator enable drops. When the pin stops toggling, whether held high by its pull-up or held low, the logic returns to the oscillator.

Activity is judged in windows of `WIN_CYC` cycles of `int_clk_i`. A window counts as active if the pin produced at least one rising edge during it. `QUAL_WIN` active windows in a row are needed before the switch. One empty window clears the qualification and ends external operation. The change between sources goes through a glitch-free two-leg multiplexer. The multiplexed clock is then divided by two to give `core_clk_o`. The timebase input `int_clk_i` has to keep running while `osc_en_o` is low, because it times the windows.

Top module: `clk_auto_sel`

## Requirements
- R1: While reset is low, and from reset release on, `osc_en_o` is 1, `ext_active_o` is 0 and `core_clk_o` has a period of two `int_clk_i` periods. Asserting reset in the middle of external operation forces `ext_active_o` to 0 and `osc_en_o` to 1 without waiting for a clock.
- R2: `ext_active_o` rises only after `QUAL_WIN` consecutive windows (default 4 windows of 32 `int_clk_i` cycles) each contained a pin rising edge. A burst shorter than that leaves the internal source selected.
- R3: A window with no pin edge clears the qualification count. Two short bursts separated by an empty window never combine into a switch.
- R4: Once external operation is in force, `osc_en_o` is 0 and `core_clk_o` has a period of two `ext_clk_i` periods.
- R5: After the pin stops toggling while held high, `ext_active_o` returns to 0 and `osc_en_o` to 1 within three windows. `core_clk_o` then runs again at half the `int_clk_i` rate.
- R6: The two multiplexer legs are never enabled together. No high or low phase of `core_clk_o` is shorter than one period of the faster source, including phases across a switch in either direction.
- R7: A pin stuck low is treated as idle in the same way as a pin held high, and the block returns to the internal source.
- R8: `ext_active_o` is 1 exactly when the external leg passes its clock. It is never 1 while the detector is not requesting the external source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| int_clk_i | input | 1 | Oscillator clock. It is also the window timebase. |
| ext_clk_i | input | 1 | External clock pin. It is pulled high when nothing drives it. |
| rst_ni | input | 1 | Asynchronous reset, active low |
| core_clk_o | output | 1 | Selected clock divided by two |
| osc_en_o | output | 1 | Oscillator enable. It is 1 while the internal source is in use. |
| ext_active_o | output | 1 | 1 while the external pin clock drives the logic |

## Verification
A wrong qualification count or window boundary shows up as `ext_active_o` rising after a burst that is too short, or failing to rise within a few windows. The bench sees this at the end of the table step in which it happens. A stuck multiplexer leg shows up as a `core_clk_o` period that does not match the status output, or as a stuck clock. The bench sees it within one period measurement. A broken handover, with both legs open or the old clock not fully gated, shows up as a `core_clk_o` phase shorter than one source period. An edge-time monitor reports the first such phase it sees.

// File: rtl/clk_det_pkg.sv
`timescale 1ns/1ps
package clk_det_pkg;
  localparam int unsigned NUM_LEGS = 2;
  localparam int unsigned LEG_INT  = 0;
  localparam int unsigned LEG_EXT  = 1;
endpackage

// File: rtl/ext_activity_mon.sv
`timescale 1ns/1ps
module ext_activity_mon #(
  parameter int unsigned WIN_CYC  = 32,
  parameter int unsigned QUAL_WIN = 4
) (
  input  logic clk_i,
  input  logic ext_clk_i,
  input  logic rst_ni,
  output logic want_ext_o,
  output logic win_end_o,
  output logic win_hit_o
);
  localparam int unsigned WIN_W = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
  localparam int unsigned QW    = $clog2(QUAL_WIN + 1);

  // pin domain: toggle on every rising edge
  logic ext_tgl_q;
  always_ff @(posedge ext_clk_i or negedge rst_ni)
    if (!rst_ni) ext_tgl_q <= 1'b0;
    else         ext_tgl_q <= ~ext_tgl_q;

  logic [2:0] tgl_sync_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) tgl_sync_q <= '0;
    else         tgl_sync_q <= {tgl_sync_q[1:0], ext_tgl_q};

  logic act;
  assign act = tgl_sync_q[2] ^ tgl_sync_q[1];

  logic [WIN_W-1:0] win_cnt_q;
  logic             seen_q;
  logic [QW-1:0]    qual_q;
  logic [QW-1:0]    qual_nxt;
  logic             want_q;

  assign win_end_o = (win_cnt_q == WIN_W'(WIN_CYC - 1));
  assign win_hit_o = seen_q | act;
  assign qual_nxt  = (qual_q == QW'(QUAL_WIN)) ? qual_q : qual_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_cnt_q <= '0;
      seen_q    <= 1'b0;
      qual_q    <= '0;
      want_q    <= 1'b0;
    end else if (win_end_o) begin
      win_cnt_q <= '0;
      seen_q    <= 1'b0;
      if (win_hit_o) begin
        qual_q <= qual_nxt;
        want_q <= (qual_nxt == QW'(QUAL_WIN));
      end else begin
        qual_q <= '0;
        want_q <= 1'b0;
      end
    end else begin
      win_cnt_q <= win_cnt_q + 1'b1;
      seen_q    <= win_hit_o;
    end
  end

  assign want_ext_o = want_q;
endmodule

// File: rtl/gf_clk_leg.sv
`timescale 1ns/1ps
module gf_clk_leg (
  input  logic clk_i,
  input  logic clr_ni,
  input  logic req_i,
  output logic en_o,
  output logic gclk_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge clr_ni)
    if (!clr_ni) s1_q <= 1'b0;
    else         s1_q <= req_i;

  // enable changes only while the clock is low
  always_ff @(negedge clk_i or negedge clr_ni)
    if (!clr_ni) s2_q <= 1'b0;
    else         s2_q <= s1_q;

  assign en_o   = s2_q;
  assign gclk_o = clk_i & s2_q;
endmodule

// File: rtl/clk_auto_sel.sv
`timescale 1ns/1ps
module clk_auto_sel
  import clk_det_pkg::*;
#(
  parameter int unsigned WIN_CYC  = 32,
  parameter int unsigned QUAL_WIN = 4
) (
  input  logic int_clk_i,
  input  logic ext_clk_i,
  input  logic rst_ni,
  output logic core_clk_o,
  output logic osc_en_o,
  output logic ext_active_o
);
  logic want_ext, win_end, win_hit;

  ext_activity_mon #(.WIN_CYC(WIN_CYC), .QUAL_WIN(QUAL_WIN)) u_mon (
    .clk_i      (int_clk_i),
    .ext_clk_i  (ext_clk_i),
    .rst_ni     (rst_ni),
    .want_ext_o (want_ext),
    .win_end_o  (win_end),
    .win_hit_o  (win_hit)
  );

  logic [NUM_LEGS-1:0] src_clk, leg_clr_n, leg_req, leg_en, leg_gclk;

  assign src_clk[LEG_INT]   = int_clk_i;
  assign src_clk[LEG_EXT]   = ext_clk_i;
  assign leg_req[LEG_INT]   = ~want_ext & ~leg_en[LEG_EXT];
  assign leg_req[LEG_EXT]   =  want_ext & ~leg_en[LEG_INT];
  assign leg_clr_n[LEG_INT] = rst_ni;
  // the pin clock is idle when deselected, so its leg drops without its clock
  assign leg_clr_n[LEG_EXT] = rst_ni & want_ext;

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    gf_clk_leg u_leg (
      .clk_i  (src_clk[g]),
      .clr_ni (leg_clr_n[g]),
      .req_i  (leg_req[g]),
      .en_o   (leg_en[g]),
      .gclk_o (leg_gclk[g])
    );
  end

  logic mux_clk;
  assign mux_clk = |leg_gclk;

  logic div_q;
  always_ff @(posedge mux_clk or negedge rst_ni)
    if (!rst_ni) div_q <= 1'b0;
    else         div_q <= ~div_q;

  assign core_clk_o   = div_q;
  assign ext_active_o = leg_en[LEG_EXT];
  assign osc_en_o     = ~leg_en[LEG_EXT];
endmodule

// File: rtl/clk_auto_sel_chk.sv
`timescale 1ns/1ps
module clk_auto_sel_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       want_ext,
  input logic       win_end,
  input logic       win_hit,
  input logic [1:0] leg_en,
  input logic       ext_active_o
);
  p_legs_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(leg_en[0] && leg_en[1]));

  p_qual_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(want_ext) |-> $past(win_end && win_hit));

  p_idle_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(want_ext) |-> $past(win_end && !win_hit));

  p_status_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_active_o |-> want_ext);
endmodule

bind clk_auto_sel clk_auto_sel_chk u_chk (
  .clk_i        (int_clk_i),
  .rst_ni       (rst_ni),
  .want_ext     (want_ext),
  .win_end      (win_end),
  .win_hit      (win_hit),
  .leg_en       (leg_en),
  .ext_active_o (ext_active_o)
);

// File: tb/sim_clk_auto_sel.sv
`timescale 1ns/1ps
module sim_clk_auto_sel;
  localparam int  WIN    = 32;
  localparam int  QUAL   = 4;
  localparam real WIN_NS = WIN * 4.0;

  logic int_clk = 1'b0, ext_clk = 1'b1, rst_ni = 1'b0;
  logic core_clk, osc_en, ext_act;
  logic [1:0] ext_mode = 2'd0; // 0 idle high, 1 toggling (14 ns), 2 idle low
  int checks = 0, errors = 0, glitches = 0;

  clk_auto_sel #(.WIN_CYC(WIN), .QUAL_WIN(QUAL)) u0 (
    .int_clk_i(int_clk), .ext_clk_i(ext_clk), .rst_ni(rst_ni),
    .core_clk_o(core_clk), .osc_en_o(osc_en), .ext_active_o(ext_act));

  always #2 int_clk = ~int_clk;

  always begin
    if (ext_mode == 2'd1) #7 ext_clk = ~ext_clk;
    else begin ext_clk = (ext_mode == 2'd0); #1; end
  end

  // R6 phase monitor
  realtime last_t = -1.0;
  always @(core_clk or negedge rst_ni) begin
    if (!rst_ni) last_t = -1.0;
    else begin
      if (last_t >= 0.0 && ($realtime - last_t) < 3.5) glitches++;
      last_t = $realtime;
    end
  end

  typedef struct packed {
    logic [1:0] mode;
    logic [3:0] nwin;
    logic       act;
    logic       osc;
    logic [7:0] per; // 0: no period check
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 4'd2, 1'b0, 1'b1, 8'd8},   // R1
    '{2'd1, 4'd2, 1'b0, 1'b1, 8'd8},   // R2 short burst
    '{2'd0, 4'd2, 1'b0, 1'b1, 8'd0},   // R3 gap
    '{2'd1, 4'd2, 1'b0, 1'b1, 8'd8},   // R3 second burst
    '{2'd1, 4'd8, 1'b1, 1'b0, 8'd28},  // R4 R8
    '{2'd0, 4'd3, 1'b0, 1'b1, 8'd8},   // R5
    '{2'd1, 4'd8, 1'b1, 1'b0, 8'd28},  // R4
    '{2'd2, 4'd3, 1'b0, 1'b1, 8'd8}    // R7
  };

  task automatic chk(input string req, input int act_v, input int exp_v);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act_v, exp_v);
    end
  endtask

  task automatic period_chk(input string req, input int exp_ns);
    realtime t0, p;
    @(posedge core_clk); t0 = $realtime;
    @(posedge core_clk); p = $realtime - t0;
    chk(req, int'(p), exp_ns);
    @(negedge int_clk); #1;
  endtask

  initial begin
    #21;
    chk("R1 reset osc_en", int'(osc_en), 1);
    chk("R1 reset ext_active", int'(ext_act), 0);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      ext_mode = TBL[i].mode;
      #(TBL[i].nwin * WIN_NS);
      chk($sformatf("R2/R3/R5/R7 step %0d ext_active", i), int'(ext_act), int'(TBL[i].act));
      chk($sformatf("R4/R5 step %0d osc_en", i), int'(osc_en), int'(TBL[i].osc));
      if (TBL[i].per != 0)
        period_chk($sformatf("R4/R8 step %0d period", i), int'(TBL[i].per));
    end
    // R1 reset during external operation
    ext_mode = 2'd1;
    #(8 * WIN_NS);
    chk("R4 pre-reset ext_active", int'(ext_act), 1);
    rst_ni = 1'b0; #1;
    chk("R1 async reset ext_active", int'(ext_act), 0);
    chk("R1 async reset osc_en", int'(osc_en), 1);
    #10 rst_ni = 1'b1; #1;
    period_chk("R1 internal after reset", 8);
    #(8 * WIN_NS);
    chk("R2 requalify after reset", int'(ext_act), 1);
    ext_mode = 2'd0;
    #(3 * WIN_NS);
    chk("R5 final revert", int'(ext_act), 0);
    chk("R6 phase monitor", glitches, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule